// File: doc/BRIEF.md
# Two-Stage I2C SCL Clock Generator

This block produces the bit timing that an I2C master's bit engine consumes. A single 8-bit clock-control register holds two fields: a 2-bit prescale selector that divides the peripheral clock by 1, 2, 3 or 4, and a 6-bit period field. The prescaler does not create a new clock. It emits a one-cycle module-clock enable, so every register in the block stays on the peripheral clock.

A second divider counts these enable pulses. It builds an SCL period of 8 × field + 20 module-clock ticks. The period is split into a low half and a high half of equal length. The block reports where it is with a phase level and with single-cycle ticks: one at the start of the low phase, one at the start of the high phase, and one exactly halfway through the low phase, where data may change.

The high half only counts while the sampled SCL line reads high. A slave that stretches the clock therefore lengthens the high phase. Software chooses the field values. It must keep the module clock below 20 MHz for the given peripheral clock. The `scl_in` input must already be synchronous to `clk`.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset, `ccr_rdata` is 0, `scl_hi` is 0, no tick is asserted, and `mod_en` is high on every cycle (prescale 0, period field 0).
- R2: A write stores `ccr_wdata` in full, and `ccr_rdata` returns it from the next cycle. Bits [1:0] are the prescale selector C, and bits [7:2] are the period field S.
- R3: `mod_en` is high on exactly one cycle in every C+1 clock cycles.
- R4: While `scl_in` stays high, consecutive `tick_low` pulses are (8·S+20)·(C+1) clock cycles apart.
- R5: The low and high halves are equal. A `tick_high` pulse comes (4·S+10)·(C+1) cycles after `tick_low`, and the next `tick_low` comes the same distance after `tick_high`.
- R6: `tick_data` comes (2·S+5)·(C+1) cycles after `tick_low`, and `tick_high` comes the same distance after `tick_data`.
- R7: A period field of 63 reads back as 63 but times the period as 62, so the period is 516·(C+1) cycles.
- R8: A write restarts both dividers. On the cycle after the write edge, `scl_hi` is 0 and no tick is asserted. The first `tick_high` is then visible (4·S+10)·(C+1) cycles later, using the newly written values.
- R9: During the high phase, the period counter holds on every edge at which `scl_in` is 0. The phase stays high, and the high half grows by one cycle for each such edge when C is 0.
- R10: Each tick lasts one cycle, at most one tick is active at a time, and `tick_high` coincides with `scl_hi` = 1 while `tick_low` and `tick_data` coincide with `scl_hi` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ccr_wr | input | 1 | Clock-control register write strobe |
| ccr_wdata | input | 8 | Clock-control write data |
| ccr_rdata | output | 8 | Clock-control register contents |
| scl_in | input | 1 | Sampled SCL line level, synchronous to clk |
| mod_en | output | 1 | Module-clock enable pulse |
| scl_hi | output | 1 | Current phase: 0 low half, 1 high half |
| tick_low | output | 1 | Start of the SCL low phase |
| tick_high | output | 1 | Start of the SCL high phase |
| tick_data | output | 1 | Data-change point, halfway through the low phase |

## Verification
The assertions check the cycle-local rules on every clock. These are the enable spacing for a nonzero prescale and the permanent enable for prescale 0, the register readback, and the restart state after a write. They also cover tick exclusivity, single-cycle width and agreement with the phase, and the rule that a high phase cannot end on an edge where SCL reads low. The exact cycle distances between ticks can only be shown by the bench's scenarios, which measure them across several field combinations. The same holds for the clamp of field 63, the latency from a write to the first high tick, and the exact lengthening of a stretched high phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    typedef struct packed {
        logic low;
        logic high;
        logic data;
    } scl_ticks_t;

endpackage

// File: rtl/scl_ccr_reg.sv
module scl_ccr_reg #(
    parameter int CDF_W    = 2,
    parameter int SCGD_W   = 6,
    parameter int SCGD_MAX = 62,
    localparam int CCR_W   = CDF_W + SCGD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CCR_W-1:0]  wr_data,
    output logic [CCR_W-1:0]  ccr,
    output logic [CDF_W-1:0]  presc_sel,
    output logic [SCGD_W-1:0] period_sel
);
    localparam logic [SCGD_W-1:0] LIMIT = SCGD_W'(SCGD_MAX);

    typedef struct packed {
        logic [CCR_W-1:0] ccr;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic [SCGD_W-1:0] field_raw;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ccr = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ccr        = st_q.ccr;
    assign presc_sel  = st_q.ccr[CDF_W-1:0];
    assign field_raw  = st_q.ccr[CCR_W-1:CDF_W];
    // Values above the legal maximum time as the maximum
    assign period_sel = (field_raw > LIMIT) ? LIMIT : field_raw;

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int CDF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CDF_W-1:0] presc_sel,
    output logic             en_pulse
);
    typedef struct packed {
        logic [CDF_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       wrap;

    assign wrap = (st_q.cnt == presc_sel);

    always_comb begin
        st_d = st_q;
        if (restart || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_pulse = wrap;

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
    import scl_gen_pkg::*;
#(
    parameter int SCGD_W = 6,
    parameter int STEP   = 8,
    parameter int BASE   = 20,
    localparam int PER_W = $clog2(STEP * ((1 << SCGD_W) - 1) + BASE + 1),
    localparam int CNT_W = PER_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              mod_en,
    input  logic [SCGD_W-1:0] period_sel,
    input  logic              scl_in,
    output logic              scl_hi,
    output scl_ticks_t        ticks
);
    typedef struct packed {
        scl_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        scl_ticks_t       ticks;
    } tmr_state_t;

    tmr_state_t       st_d, st_q;
    logic [PER_W-1:0] per_len;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] mid_cnt;
    logic             at_last;

    // Full period in module ticks, then one half of it
    assign per_len  = PER_W'(STEP) * PER_W'(period_sel) + PER_W'(BASE);
    assign half_len = per_len[PER_W-1:1];
    assign last_cnt = half_len - 1'b1;
    assign mid_cnt  = (half_len >> 1) - 1'b1;
    assign at_last  = (st_q.cnt == last_cnt);

    always_comb begin
        st_d       = st_q;
        st_d.ticks = '0;
        if (restart) begin
            st_d.phase = PH_LOW;
            st_d.cnt   = '0;
        end else if (mod_en) begin
            if (st_q.phase == PH_LOW) begin
                if (at_last) begin
                    st_d.phase      = PH_HIGH;
                    st_d.cnt        = '0;
                    st_d.ticks.high = 1'b1;
                end else begin
                    st_d.cnt        = st_q.cnt + 1'b1;
                    st_d.ticks.data = (st_q.cnt == mid_cnt);
                end
            end else if (scl_in) begin
                // High half only advances while the line reads high
                if (at_last) begin
                    st_d.phase     = PH_LOW;
                    st_d.cnt       = '0;
                    st_d.ticks.low = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_LOW, cnt: '0, ticks: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_hi = (st_q.phase == PH_HIGH);
    assign ticks  = st_q.ticks;

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import scl_gen_pkg::*;
#(
    parameter int CDF_W    = 2,
    parameter int SCGD_W   = 6,
    parameter int SCGD_MAX = 62,
    parameter int STEP     = 8,
    parameter int BASE     = 20,
    localparam int CCR_W   = CDF_W + SCGD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ccr_wr,
    input  logic [CCR_W-1:0] ccr_wdata,
    output logic [CCR_W-1:0] ccr_rdata,
    input  logic             scl_in,
    output logic             mod_en,
    output logic             scl_hi,
    output logic             tick_low,
    output logic             tick_high,
    output logic             tick_data
);
    logic [CDF_W-1:0]  presc_sel;
    logic [SCGD_W-1:0] period_sel;
    scl_ticks_t        ticks;

    scl_ccr_reg #(
        .CDF_W    (CDF_W),
        .SCGD_W   (SCGD_W),
        .SCGD_MAX (SCGD_MAX)
    ) ccr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ccr_wr),
        .wr_data    (ccr_wdata),
        .ccr        (ccr_rdata),
        .presc_sel  (presc_sel),
        .period_sel (period_sel)
    );

    scl_prescaler #(
        .CDF_W (CDF_W)
    ) pre_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (ccr_wr),
        .presc_sel (presc_sel),
        .en_pulse  (mod_en)
    );

    scl_phase_timer #(
        .SCGD_W (SCGD_W),
        .STEP   (STEP),
        .BASE   (BASE)
    ) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (ccr_wr),
        .mod_en     (mod_en),
        .period_sel (period_sel),
        .scl_in     (scl_in),
        .scl_hi     (scl_hi),
        .ticks      (ticks)
    );

    assign tick_low  = ticks.low;
    assign tick_high = ticks.high;
    assign tick_data = ticks.data;

endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk #(
    parameter int CDF_W  = 2,
    parameter int CCR_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ccr_wr,
    input logic [CCR_W-1:0] ccr_wdata,
    input logic [CCR_W-1:0] ccr_rdata,
    input logic             scl_in,
    input logic             mod_en,
    input logic             scl_hi,
    input logic             tick_low,
    input logic             tick_high,
    input logic             tick_data
);
    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_wr |=> (ccr_rdata == $past(ccr_wdata)));

    assert_enable_always_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_rdata[CDF_W-1:0] == '0) |-> mod_en);

    assert_enable_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && (ccr_rdata[CDF_W-1:0] != '0) && !ccr_wr) |=> !mod_en);

    assert_restart_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_wr |=> (!scl_hi && !tick_low && !tick_high && !tick_data));

    assert_stretch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hi && !scl_in && !ccr_wr) |=> scl_hi);

    assert_ticks_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tick_low, tick_high, tick_data}));

    assert_high_tick_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_high |-> scl_hi);

    assert_low_tick_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_low || tick_data) |-> !scl_hi);

    assert_low_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_low |=> !tick_low);

endmodule

bind scl_clock_gen scl_clock_gen_chk #(
    .CDF_W (CDF_W),
    .CCR_W (CCR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ccr_wr    (ccr_wr),
    .ccr_wdata (ccr_wdata),
    .ccr_rdata (ccr_rdata),
    .scl_in    (scl_in),
    .mod_en    (mod_en),
    .scl_hi    (scl_hi),
    .tick_low  (tick_low),
    .tick_high (tick_high),
    .tick_data (tick_data)
);

// File: tb/scl_clock_gen_tb_top.sv
`timescale 1ns/1ps
module scl_clock_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ccr_wr = 1'b0;
    logic [7:0] ccr_wdata = '0;
    logic [7:0] ccr_rdata;
    logic       scl_in = 1'b1;
    logic       mod_en, scl_hi, tick_low, tick_high, tick_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    scl_clock_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ccr_wr    (ccr_wr),
        .ccr_wdata (ccr_wdata),
        .ccr_rdata (ccr_rdata),
        .scl_in    (scl_in),
        .mod_en    (mod_en),
        .scl_hi    (scl_hi),
        .tick_low  (tick_low),
        .tick_high (tick_high),
        .tick_data (tick_data)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic logic tick_of(input int sel);
        case (sel)
            0:       return tick_low;
            1:       return tick_high;
            default: return tick_data;
        endcase
    endfunction

    // Counts negedges until the selected tick is seen
    task automatic count_until(input int sel, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_of(sel) && n < 5000);
    endtask

    // Drives one write; returns at the negedge after the write edge
    task automatic write_ccr(input logic [7:0] v);
        @(negedge clk);
        ccr_wr    = 1'b1;
        ccr_wdata = v;
        @(negedge clk);
        ccr_wr    = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 rdata", int'(ccr_rdata), 0);
        check("R1 phase", int'(scl_hi), 0);
        check("R1 ticks", int'({tick_low, tick_high, tick_data}), 0);
        check("R1 mod_en", int'(mod_en), 1);
    endtask

    task automatic t_readback();
        write_ccr(8'hA7);
        check("R2 readback A7", int'(ccr_rdata), 8'hA7);
        write_ccr(8'h5A);
        check("R2 readback 5A", int'(ccr_rdata), 8'h5A);
    endtask

    task automatic t_prescale(input int c);
        int hits;
        write_ccr(8'(c));
        hits = 0;
        for (int i = 0; i < 12 * (c + 1); i++) begin
            @(negedge clk);
            if (mod_en) hits++;
        end
        check($sformatf("R3 enable count cdf=%0d", c), hits, 12);
    endtask

    task automatic t_period(input int s, input int c);
        int n;
        int half;
        half = 4 * s + 10;
        write_ccr(8'((s << 2) | c));
        count_until(0, n);
        count_until(2, n);
        check($sformatf("R6 low->data s=%0d c=%0d", s, c), n, (2 * s + 5) * (c + 1));
        count_until(1, n);
        check($sformatf("R6 data->high s=%0d c=%0d", s, c), n, (2 * s + 5) * (c + 1));
        count_until(0, n);
        check($sformatf("R5 high->low s=%0d c=%0d", s, c), n, half * (c + 1));
        count_until(0, n);
        check($sformatf("R4 period s=%0d c=%0d", s, c), n, (8 * s + 20) * (c + 1));
    endtask

    task automatic t_clamp();
        int n;
        write_ccr(8'hFC);
        check("R7 readback 63", int'(ccr_rdata), 8'hFC);
        count_until(0, n);
        count_until(0, n);
        check("R7 clamped period", n, 516);
    endtask

    task automatic t_restart();
        int n;
        write_ccr(8'h01);
        repeat (7) @(negedge clk);
        write_ccr(8'((2 << 2) | 1));
        check("R8 phase low after write", int'(scl_hi), 0);
        count_until(1, n);
        check("R8 first high tick", n, 18 * 2);
    endtask

    task automatic t_stretch();
        int n;
        bit stayed;
        write_ccr(8'h00);
        count_until(1, n);
        scl_in = 1'b0;
        stayed = 1'b1;
        repeat (7) begin
            @(negedge clk);
            if (!scl_hi) stayed = 1'b0;
        end
        scl_in = 1'b1;
        check("R9 phase held high", int'(stayed), 1);
        count_until(0, n);
        check("R9 stretched high half", n + 7, 17);
    endtask

    task automatic t_tick_width();
        int overlap;
        int width_err;
        logic prev_low;
        overlap = 0;
        width_err = 0;
        prev_low = 1'b0;
        write_ccr(8'((1 << 2) | 0));
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (int'(tick_low) + int'(tick_high) + int'(tick_data) > 1) overlap++;
            if (tick_low && prev_low) width_err++;
            if (tick_high && !scl_hi) overlap++;
            prev_low = tick_low;
        end
        check("R10 tick overlap", overlap, 0);
        check("R10 tick width", width_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_prescale(0);
        t_prescale(1);
        t_prescale(3);
        t_period(0, 0);
        t_period(3, 1);
        t_period(1, 3);
        t_period(62, 0);
        t_clamp();
        t_restart();
        t_stretch();
        t_tick_width();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule